// File: doc/BRIEF.md
# Lowest Set Bit Locator

This block finds the least significant '1' in a wide input word over several clock cycles. It does not use one large priority encoder. A start pulse loads the word into a working window register. The search then halves the window once per cycle. Each cycle it checks whether the low half of the window holds any set bit. If it does, the search keeps that half. If it does not, the window shifts right by the half width and a running offset grows by the same amount.

After log2 of the padded width steps, the window has shrunk to one known-set bit at position zero. The block then reports the offset plus one as a 1-based position, together with a one-cycle done pulse. A word with no set bit skips the search and reports 0 one cycle after capture. The input width is a parameter (default 512). A width that is not a power of two is padded with zeros up to the next power of two. The block is used wherever a wide request or event vector must be turned into an index and a few cycles of latency are acceptable.

Top module: `lsb_search`

## Requirements
- R1: For a nonzero word, `result` equals one plus the index of its lowest set bit. Bit 0 set gives 1, bit VEC_W-1 alone gives VEC_W, and 8'b1000_1000 gives 4.
- R2: An all-zero word gives `result` = 0, with `done` high one cycle after the capture edge.
- R3: The word is captured on the rising edge where `start` is high and the block is idle. Changing `vec_in` after that edge has no effect on the reported result.
- R4: For a nonzero word, `done` rises log2(padded width) cycles after the capture edge. That is 9 cycles for the default 512 bits.
- R5: `done` is high for exactly one cycle. `result` keeps its value until the next `done`.
- R6: `busy` is high from the cycle after capture up to, but not including, the cycle in which `done` is high.
- R7: A `start` pulse while `busy` is high is ignored. It neither changes the result nor the latency, and it does not launch a second search.
- R8: While reset is asserted and right after it, `busy` = 0, `done` = 0 and `result` = 0. A reset in the middle of a search abandons that search.
- R9: A `start` in the same cycle that `done` is high is accepted, so back-to-back searches need no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Capture `vec_in` and begin a search when idle |
| vec_in | input | VEC_W | Word to be searched |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse: `result` is valid and new |
| result | output | $clog2(VEC_W+1) | 1-based index of the lowest set bit, 0 when none |

## Verification
The case that needs care is the cycle where one search's done pulse and the next search's start meet. The bench raises `start` with a fresh word exactly in the cycle where `done` is seen high. In that same cycle it checks the old result. It then confirms that the new word is reported with the correct position after the full latency. A start pulse in the middle of a search is also driven, and the bench judges that the first result and its timing are unchanged and that `busy` does not come back afterwards. Every table entry also changes `vec_in` right after capture, so a result that leaks from the live input is caught.

// File: rtl/lss_pkg.sv
package lss_pkg;

  // Sequencer states of the locator
  typedef enum logic [1:0] {
    LSS_IDLE = 2'd0,
    LSS_ZERO = 2'd1,
    LSS_SCAN = 2'd2
  } lss_state_e;

endpackage

// File: rtl/lss_ctrl.sv
// Sequencer: accepts start when idle, walks the halving steps, and takes the
// short path for an all-zero word.
module lss_ctrl
  import lss_pkg::*;
#(
  parameter int STEPS  = 9,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              vec_nz,
  output logic              load,
  output logic              scan,
  output logic              last_step,
  output logic              zero_fin,
  output logic              busy,
  output logic [STEP_W-1:0] step
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS - 1);

  lss_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              idle;

  // decoded outputs
  always_comb begin
    idle      = (state_q == LSS_IDLE);
    load      = start & idle;
    scan      = (state_q == LSS_SCAN);
    last_step = scan && (step_q == LAST_STEP);
    zero_fin  = (state_q == LSS_ZERO);
    busy      = !idle;
    step      = step_q;
  end

  // next state
  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    unique case (state_q)
      LSS_IDLE: begin
        if (start) begin
          step_d  = '0;
          state_d = vec_nz ? LSS_SCAN : LSS_ZERO;
        end
      end
      LSS_ZERO: begin
        state_d = LSS_IDLE;
      end
      LSS_SCAN: begin
        if (step_q == LAST_STEP) begin
          state_d = LSS_IDLE;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      default: begin
        state_d = LSS_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LSS_IDLE;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) scan |-> (step_q <= LAST_STEP)); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start)); // R3
  AST_ZERO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) zero_fin |=> !busy); // R2

endmodule

// File: rtl/lss_half_probe.sv
// One OR-reduction per halving step over the low bits of the window; the
// current step selects which reduction counts.
module lss_half_probe #(
  parameter int PAD_W  = 512,
  parameter int STEPS  = 9,
  parameter int STEP_W = 4
) (
  input  logic [PAD_W/2-1:0] win_lo,
  input  logic [STEP_W-1:0]  step,
  output logic               lower_any
);

  logic [STEPS-1:0] any_k;

  for (genvar k = 0; k < STEPS; k++) begin : g_probe
    localparam int HALF_W = PAD_W >> (k + 1);
    assign any_k[k] = |win_lo[HALF_W-1:0];
  end

  assign lower_any = any_k[step];

endmodule

// File: rtl/lss_window.sv
// Working window register and offset counter. On an empty low half the
// window shifts right by the half width and the offset grows by it.
module lss_window #(
  parameter int VEC_W  = 512,
  parameter int PAD_W  = 512,
  parameter int STEPS  = 9,
  parameter int STEP_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               scan,
  input  logic               last_step,
  input  logic               lower_any,
  input  logic [STEP_W-1:0]  step,
  input  logic [VEC_W-1:0]   vec_in,
  output logic [PAD_W/2-1:0] win_lo,
  output logic [STEPS-1:0]   offset_nxt
);

  logic [PAD_W-1:0]  win_q, win_d;
  logic [STEPS-1:0]  off_q, off_d;
  logic [STEP_W-1:0] shamt;
  logic [STEPS-1:0]  half_amt;
  logic              discard;

  always_comb begin
    shamt    = STEP_W'(STEPS - 1) - step;
    half_amt = STEPS'(1) << shamt;
    discard  = scan && !lower_any;
    win_d    = win_q;
    off_d    = off_q;
    if (load) begin
      win_d = PAD_W'(vec_in);
      off_d = '0;
    end else if (discard) begin
      win_d = win_q >> half_amt;
      off_d = off_q + half_amt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      off_q <= '0;
    end else begin
      if (load || discard) begin
        win_q <= win_d;
        off_q <= off_d;
      end
    end
  end

  assign win_lo     = win_q[PAD_W/2-1:0];
  assign offset_nxt = off_d;

  AST_LAST_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n) last_step |-> (win_q[1:0] != 2'b00)); // R1
  AST_OFFSET_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) scan |=> (int'(off_q) < VEC_W)); // R1

endmodule

// File: rtl/lsb_search.sv
// Multi-cycle locator of the lowest set bit, 1-based result, 0 for none.
module lsb_search #(
  parameter int VEC_W = 512,
  localparam int STEPS  = $clog2(VEC_W),
  localparam int PAD_W  = 1 << STEPS,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int RES_W  = $clog2(VEC_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VEC_W-1:0] vec_in,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);

  logic              load, scan, last_step, zero_fin, lower_any, vec_nz;
  logic [STEP_W-1:0] step;
  logic [PAD_W/2-1:0] win_lo;
  logic [STEPS-1:0]  offset_nxt;
  logic              done_q, done_d;
  logic [RES_W-1:0]  res_q, res_d;

  assign vec_nz = |vec_in;

  lss_ctrl #(
    .STEPS (STEPS),
    .STEP_W(STEP_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vec_nz   (vec_nz),
    .load     (load),
    .scan     (scan),
    .last_step(last_step),
    .zero_fin (zero_fin),
    .busy     (busy),
    .step     (step)
  );

  lss_half_probe #(
    .PAD_W (PAD_W),
    .STEPS (STEPS),
    .STEP_W(STEP_W)
  ) u_probe (
    .win_lo   (win_lo),
    .step     (step),
    .lower_any(lower_any)
  );

  lss_window #(
    .VEC_W (VEC_W),
    .PAD_W (PAD_W),
    .STEPS (STEPS),
    .STEP_W(STEP_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .scan      (scan),
    .last_step (last_step),
    .lower_any (lower_any),
    .step      (step),
    .vec_in    (vec_in),
    .win_lo    (win_lo),
    .offset_nxt(offset_nxt)
  );

  // result and completion pulse
  always_comb begin
    done_d = last_step | zero_fin;
    res_d  = res_q;
    if (last_step) begin
      res_d = RES_W'(offset_nxt) + RES_W'(1);
    end else if (zero_fin) begin
      res_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= done_d;
      if (done_d) begin
        res_q <= res_d;
      end
    end
  end

  assign done   = done_q;
  assign result = res_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result)); // R5
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (int'(result) <= VEC_W)); // R1

endmodule

// File: tb/lsb_search_tb.sv
module lsb_search_tb;

  localparam int VEC_W = 512;
  localparam int RES_W = $clog2(VEC_W + 1);
  localparam int LAT   = 9;
  localparam int NTV   = 9;

  localparam logic [VEC_W-1:0] TV_VEC [NTV] = '{
    512'd0,
    512'd1,
    512'h88,
    (512'd1 << 511),
    {VEC_W{1'b1}},
    (512'd1 << 511) | (512'd1 << 255),
    (512'd1 << 256),
    (512'hF0 << 100),
    (512'd1 << 300) | (512'd1 << 400)
  };
  localparam int TV_EXP [NTV] = '{0, 1, 4, 512, 1, 256, 257, 105, 301};

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [VEC_W-1:0] vec_in;
  logic             busy;
  logic             done;
  logic [RES_W-1:0] result;

  int total = 0;
  int bad   = 0;
  bit summary_out = 0;

  lsb_search #(.VEC_W(VEC_W)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .vec_in(vec_in),
    .busy  (busy),
    .done  (done),
    .result(result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_out) begin
      summary_out = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  // Drive at a negedge; returns at the negedge after the capture edge,
  // with the input already scrambled (R3).
  task automatic launch(input logic [VEC_W-1:0] v);
    start  = 1'b1;
    vec_in = v;
    @(posedge clk);
    @(negedge clk);
    start  = 1'b0;
    vec_in = ~v;
  endtask

  // Count edges after capture until done, checking busy on the way.
  task automatic wait_done(input int exp, input int exp_lat, input int n0, input string tag);
    int  n = n0;
    bit  busy_ok = 1;
    while (!done && n < 40) begin
      if (!busy) busy_ok = 0;
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, {"R4 done seen ", tag}, int'(done), 1);
    chk(n == exp_lat, {"R4 R2 latency ", tag}, n, exp_lat);
    chk(int'(result) == exp, {"R1 R2 R3 result ", tag}, int'(result), exp);
    chk(busy_ok && (busy === 1'b0), {"R6 busy window ", tag}, int'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    vec_in = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy === 1'b0 && done === 1'b0, "R8 flags in reset", int'(busy) + int'(done), 0);
    chk(int'(result) == 0, "R8 result in reset", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result == '0, "R8 after release", int'(result), 0);

    // table of vectors
    for (int i = 0; i < NTV; i++) begin
      launch(TV_VEC[i]);
      wait_done(TV_EXP[i], (TV_EXP[i] == 0) ? 1 : LAT, 0, $sformatf("tv%0d", i));
      @(posedge clk);
      @(negedge clk);
      // R5 pulse width and hold
      chk(done === 1'b0, "R5 done one cycle", int'(done), 0);
      chk(int'(result) == TV_EXP[i], "R5 result held", int'(result), TV_EXP[i]);
    end

    // R7 start during busy is ignored
    launch(512'd1 << 511);
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
    end
    start  = 1'b1;
    vec_in = 512'd1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(512, LAT, 4, "R7 busy start");
    @(posedge clk);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R7 no second search", int'(busy), 0);
    chk(int'(result) == 512, "R7 result unchanged", int'(result), 512);

    // R9 back-to-back: start in the done cycle
    launch(512'd1 << 37);
    wait_done(38, LAT, 0, "R9 first");
    launch(512'h88);
    wait_done(4, LAT, 0, "R9 second");
    // zero search back-to-back with zero search
    launch(512'd0);
    wait_done(0, 1, 0, "R9 zero first");
    launch(512'd0);
    wait_done(0, 1, 0, "R9 zero second");

    // R8 reset in mid search
    launch(512'd1 << 400);
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
    end
    launch(512'd1 << 3);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && result == '0, "R8 mid-search reset", int'(busy) + int'(result), 0);
    rst_n = 1'b1;
    repeat (12) begin
      @(posedge clk);
      @(negedge clk);
      if (done) chk(1'b0, "R8 stale done after reset", 1, 0);
    end
    chk(busy === 1'b0, "R8 idle after reset", int'(busy), 0);
    launch(512'd1 << 9);
    wait_done(10, LAT, 0, "R8 after reset");

    summary();
    $finish;
  end

endmodule